// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Emulator

This block is a synthesizable stand-in for an asynchronous static RAM that is organised as 16-bit words split into two byte lanes. The RAM has active-low chip, output and write controls and one active-low enable per byte lane. Instead of real tri-state pins, it returns a read-data bus together with a per-lane drive vector. A pad ring or a bus model can use that vector to decide when each lane is actually driven. All control pins are sampled on one fast clock, so the asynchronous protocol of the part is rebuilt from successive samples.

In each sample the block decodes one of four modes: standby, read, write or output-off. It drives only those lanes whose byte enable is low, and only in read mode. A write is framed by the overlap of chip enable low and write enable low. The write takes effect once, when the overlap ends. Address, data and lane mask come from the last sample that was still inside the overlap. The storage depth is 2^ADDR_W words. Setting ADDR_W to 17 gives the full 131,072-word array; the default is kept small for elaboration.

Top module: `sram_byte_lane_emu`

## Requirements
- R1: The array holds 2^ADDR_W words of LANES*LANE_W bits. A word written at address 0 or at the highest address reads back unchanged.
- R2: When the sampled chip enable is high, lane_oe is all zero, whatever the other pins are. A write-enable pulse while chip enable is high changes no stored word.
- R3: In read mode (chip enable low, output enable low, write enable high), lane_oe[i] is 1 exactly when be_n[i] is low, and that lane of rdata carries the stored byte. Lane 0 is bits 7:0; lane 1 is bits 15:8.
- R4: A write updates only the lanes whose be_n bit is low. The other lane of the word keeps its old value.
- R5: While chip enable and write enable are both low, lane_oe is all zero, even with output enable low.
- R6: With chip enable low, lane_oe is all zero if output enable and write enable are both high, or if every be_n bit is high.
- R7: A write window opens at the first sample in which both chip enable and write enable are low. It commits exactly once, at the first later sample in which either of them is high. The window may close on either pin, in either order of falling edges.
- R8: The committed address, data and lane mask are those of the last sample inside the window. Values seen earlier in the window have no effect.
- R9: Pins sampled at clock edge k are reflected on rdata and lane_oe after edge k. If a window's closing sample is taken at edge k, a read of that word shows the old value after edge k and the new value after edge k+1.
- R10: While rst_n is low, the sampled pins are held in the idle state (all controls high). After reset, lane_oe is zero and no write takes place.
- R11: Each lane of rdata is zero whenever its lane_oe bit is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset of the sample registers |
| addr | input | ADDR_W | Word address |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| be_n | input | LANES | Byte-lane enables, active low; bit i selects lane i |
| wdata | input | LANES*LANE_W | Write data |
| rdata | output | LANES*LANE_W | Read data; a lane is zero when it is not driven |
| lane_oe | output | LANES | Per-lane drive enable, standing in for tri-state control |

## Verification
The assertions take for granted that pins change only between sampling edges. Their $past terms then describe exactly what the sample registers captured. They also assume that nothing of interest happens before rst_n has been low for at least one edge. The bench drives every pin one time unit after an edge and holds it through the next edge. It releases reset only after several edges. It never changes a pin during the edge at which a check reads the outputs.

// File: rtl/sram_emu_pkg.sv
package sram_emu_pkg;

    typedef enum logic [1:0] {
        MODE_STANDBY = 2'd0,
        MODE_READ    = 2'd1,
        MODE_WRITE   = 2'd2,
        MODE_OUT_OFF = 2'd3
    } sram_mode_e;

endpackage

// File: rtl/sram_pin_sampler.sv
module sram_pin_sampler #(
    parameter int ADDR_W = 10,
    parameter int LANES  = 2,
    parameter int LANE_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         addr,
    input  logic                      ce_n,
    input  logic                      oe_n,
    input  logic                      we_n,
    input  logic [LANES-1:0]          be_n,
    input  logic [LANES*LANE_W-1:0]   wdata,
    output logic [ADDR_W-1:0]         s_addr,
    output logic                      s_ce_n,
    output logic                      s_oe_n,
    output logic                      s_we_n,
    output logic [LANES-1:0]          s_be_n,
    output logic [ADDR_W-1:0]         p_addr,
    output logic                      p_ce_n,
    output logic                      p_we_n,
    output logic [LANES-1:0]          p_be_n,
    output logic [LANES*LANE_W-1:0]   p_wdata
);
    localparam int DATA_W = LANES * LANE_W;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              ce_n;
        logic              oe_n;
        logic              we_n;
        logic [LANES-1:0]  be_n;
        logic [DATA_W-1:0] wdata;
    } pins_t;

    typedef struct packed {
        pins_t cur;
        pins_t prev;
    } smp_t;

    localparam pins_t PINS_IDLE = '{addr: '0, ce_n: 1'b1, oe_n: 1'b1,
                                   we_n: 1'b1, be_n: '1, wdata: '0};

    smp_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = st_q.cur;
        st_d.cur  = '{addr: addr, ce_n: ce_n, oe_n: oe_n,
                      we_n: we_n, be_n: be_n, wdata: wdata};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{cur: PINS_IDLE, prev: PINS_IDLE};
        end else begin
            st_q <= st_d;
        end
    end

    assign s_addr  = st_q.cur.addr;
    assign s_ce_n  = st_q.cur.ce_n;
    assign s_oe_n  = st_q.cur.oe_n;
    assign s_we_n  = st_q.cur.we_n;
    assign s_be_n  = st_q.cur.be_n;
    assign p_addr  = st_q.prev.addr;
    assign p_ce_n  = st_q.prev.ce_n;
    assign p_we_n  = st_q.prev.we_n;
    assign p_be_n  = st_q.prev.be_n;
    assign p_wdata = st_q.prev.wdata;

    // R10: the first sample after reset is always idle
    p_idle_after_reset_r10: assert property (@(posedge clk)
        $rose(rst_n) |-> (s_ce_n && s_we_n && s_oe_n));

endmodule

// File: rtl/sram_mode_decode.sv
module sram_mode_decode
    import sram_emu_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic             s_ce_n,
    input  logic             s_oe_n,
    input  logic             s_we_n,
    input  logic [LANES-1:0] s_be_n,
    output sram_mode_e       mode,
    output logic [LANES-1:0] lane_drive
);
    always_comb begin
        if (s_ce_n) begin
            mode = MODE_STANDBY;
        end else if (!s_we_n) begin
            mode = MODE_WRITE;
        end else if (!s_oe_n && !(&s_be_n)) begin
            mode = MODE_READ;
        end else begin
            mode = MODE_OUT_OFF;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_drive[g] = (mode == MODE_READ) && !s_be_n[g];
    end

endmodule

// File: rtl/sram_write_window.sv
module sram_write_window #(
    parameter int ADDR_W = 10,
    parameter int LANES  = 2,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    s_ce_n,
    input  logic                    s_we_n,
    input  logic                    p_ce_n,
    input  logic                    p_we_n,
    input  logic [ADDR_W-1:0]       p_addr,
    input  logic [LANES-1:0]        p_be_n,
    input  logic [LANES*LANE_W-1:0] p_wdata,
    output logic                    commit,
    output logic [LANES-1:0]        c_lane_we,
    output logic [ADDR_W-1:0]       c_addr,
    output logic [LANES*LANE_W-1:0] c_wdata
);
    logic win_now;
    logic win_prev;

    always_comb begin
        win_now   = !s_ce_n && !s_we_n;
        win_prev  = !p_ce_n && !p_we_n;
        commit    = win_prev && !win_now;
        c_lane_we = commit ? ~p_be_n : '0;
        c_addr    = p_addr;
        c_wdata   = p_wdata;
    end

    // R7: a window cannot close on two consecutive samples
    p_commit_spaced_r7: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);

endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array #(
    parameter int ADDR_W = 10,
    parameter int LANES  = 2,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic [LANES-1:0]        w_lane_we,
    input  logic [ADDR_W-1:0]       w_addr,
    input  logic [LANES*LANE_W-1:0] w_data,
    input  logic [ADDR_W-1:0]       r_addr,
    input  logic [LANES-1:0]        r_drive,
    output logic [LANES*LANE_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem_q [DEPTH];

        always_ff @(posedge clk) begin
            if (w_lane_we[g]) begin
                mem_q[w_addr] <= w_data[g*LANE_W +: LANE_W];
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = r_drive[g] ? mem_q[r_addr] : '0;
    end

endmodule

// File: rtl/sram_byte_lane_emu.sv
module sram_byte_lane_emu
    import sram_emu_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANES  = 2,
    parameter int LANE_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         addr,
    input  logic                      ce_n,
    input  logic                      oe_n,
    input  logic                      we_n,
    input  logic [LANES-1:0]          be_n,
    input  logic [LANES*LANE_W-1:0]   wdata,
    output logic [LANES*LANE_W-1:0]   rdata,
    output logic [LANES-1:0]          lane_oe
);
    localparam int DATA_W = LANES * LANE_W;

    logic [ADDR_W-1:0] s_addr, p_addr, c_addr;
    logic              s_ce_n, s_oe_n, s_we_n, p_ce_n, p_we_n;
    logic [LANES-1:0]  s_be_n, p_be_n, c_lane_we, lane_drive;
    logic [DATA_W-1:0] p_wdata, c_wdata;
    logic              commit;
    sram_mode_e        mode;

    sram_pin_sampler #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_sampler (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .oe_n(oe_n),
        .we_n(we_n), .be_n(be_n), .wdata(wdata),
        .s_addr(s_addr), .s_ce_n(s_ce_n), .s_oe_n(s_oe_n), .s_we_n(s_we_n),
        .s_be_n(s_be_n), .p_addr(p_addr), .p_ce_n(p_ce_n), .p_we_n(p_we_n),
        .p_be_n(p_be_n), .p_wdata(p_wdata)
    );

    sram_mode_decode #(.LANES(LANES)) u_decode (
        .s_ce_n(s_ce_n), .s_oe_n(s_oe_n), .s_we_n(s_we_n), .s_be_n(s_be_n),
        .mode(mode), .lane_drive(lane_drive)
    );

    sram_write_window #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_window (
        .clk(clk), .rst_n(rst_n), .s_ce_n(s_ce_n), .s_we_n(s_we_n),
        .p_ce_n(p_ce_n), .p_we_n(p_we_n), .p_addr(p_addr), .p_be_n(p_be_n),
        .p_wdata(p_wdata), .commit(commit), .c_lane_we(c_lane_we),
        .c_addr(c_addr), .c_wdata(c_wdata)
    );

    sram_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk(clk), .w_lane_we(c_lane_we), .w_addr(c_addr), .w_data(c_wdata),
        .r_addr(s_addr), .r_drive(lane_drive), .rdata(rdata)
    );

    assign lane_oe = lane_drive;

    // R2: standby sampled on the previous edge leaves every lane undriven
    p_standby_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ce_n) |-> (lane_oe == '0));

    // R5: an open write window never drives the lanes
    p_write_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!ce_n && !we_n) |-> (lane_oe == '0));

    // R7: a commit follows an in-window sample and a closing sample
    p_commit_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> ($past(!ce_n && !we_n, 2) && !$past(!ce_n && !we_n)));

    for (genvar g = 0; g < LANES; g++) begin : g_chk
        // R3: a driven lane implies a read sample with that lane enabled
        p_read_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
            lane_oe[g] |-> $past(!ce_n && !oe_n && we_n && !be_n[g]));
        // R11: an undriven lane carries zero
        p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
            !lane_oe[g] |-> (rdata[g*LANE_W +: LANE_W] == '0));
    end

endmodule

// File: tb/sram_byte_lane_emu_tb.sv
module sram_byte_lane_emu_tb;
    localparam int ADDR_W = 10;
    localparam int LANES  = 2;
    localparam int LANE_W = 8;
    localparam int DATA_W = LANES * LANE_W;
    localparam logic [ADDR_W-1:0] TOP_ADDR = '1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic              ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [LANES-1:0]  be_n = '1;
    logic [DATA_W-1:0] wdata = '0;
    logic [DATA_W-1:0] rdata;
    logic [LANES-1:0]  lane_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sram_byte_lane_emu #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .oe_n(oe_n),
        .we_n(we_n), .be_n(be_n), .wdata(wdata), .rdata(rdata), .lane_oe(lane_oe)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_pins();
        ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; be_n = '1;
    endtask

    task automatic do_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                            input logic [LANES-1:0] ben);
        addr = a; wdata = d; be_n = ben; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
        tick();
        we_n = 1'b1;
        tick();
        idle_pins();
        tick();
        tick();
    endtask

    task automatic do_read(input logic [ADDR_W-1:0] a, input logic [LANES-1:0] ben,
                           input logic [LANES-1:0] exp_oe, input logic [DATA_W-1:0] exp_d,
                           input string req);
        addr = a; be_n = ben; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        tick();
        chk(lane_oe == exp_oe, req, 32'(lane_oe), 32'(exp_oe));
        chk(rdata == exp_d, req, 32'(rdata), 32'(exp_d));
        idle_pins();
        tick();
    endtask

    task automatic t_reset();
        chk(lane_oe == '0, "R10 lane_oe after reset", 32'(lane_oe), 0);
        chk(rdata == '0, "R11 rdata zero when undriven", 32'(rdata), 0);
    endtask

    task automatic t_word_rw();
        do_write('0, 16'hA5C3, 2'b00);
        do_write(TOP_ADDR, 16'h3C5A, 2'b00);
        do_read('0, 2'b00, 2'b11, 16'hA5C3, "R1 word at address 0");
        do_read(TOP_ADDR, 2'b00, 2'b11, 16'h3C5A, "R1 word at top address");
    endtask

    task automatic t_byte_write();
        do_write(10'd5, 16'h1111, 2'b00);
        do_write(10'd5, 16'h22BB, 2'b10);
        do_read(10'd5, 2'b00, 2'b11, 16'h11BB, "R4 low lane only");
        do_write(10'd5, 16'hCC99, 2'b01);
        do_read(10'd5, 2'b00, 2'b11, 16'hCCBB, "R4 high lane only");
        do_write(10'd5, 16'h7777, 2'b11);
        do_read(10'd5, 2'b00, 2'b11, 16'hCCBB, "R4 no lane enabled");
    endtask

    task automatic t_byte_read();
        do_read(10'd5, 2'b10, 2'b01, 16'h00BB, "R3 R11 low lane read");
        do_read(10'd5, 2'b01, 2'b10, 16'hCC00, "R3 R11 high lane read");
    endtask

    task automatic t_standby();
        addr = 10'd5; ce_n = 1'b1; oe_n = 1'b0; we_n = 1'b1; be_n = 2'b00;
        tick();
        chk(lane_oe == '0, "R2 standby with read pins", 32'(lane_oe), 0);
        do_write(10'd9, 16'h1234, 2'b00);
        addr = 10'd9; wdata = 16'hFFFF; be_n = 2'b00; ce_n = 1'b1; we_n = 1'b0;
        tick();
        chk(lane_oe == '0, "R2 standby during we pulse", 32'(lane_oe), 0);
        we_n = 1'b1;
        tick();
        tick();
        do_read(10'd9, 2'b00, 2'b11, 16'h1234, "R2 R7 we pulse without ce");
    endtask

    task automatic t_out_off();
        addr = 10'd5; ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1; be_n = 2'b00;
        tick();
        chk(lane_oe == '0, "R6 oe and we high", 32'(lane_oe), 0);
        chk(rdata == '0, "R11 zero when disabled", 32'(rdata), 0);
        oe_n = 1'b0; be_n = 2'b11;
        tick();
        chk(lane_oe == '0, "R6 both byte enables high", 32'(lane_oe), 0);
        idle_pins();
        tick();
    endtask

    task automatic t_ce_close();
        addr = 10'd12; wdata = 16'h6A6A; be_n = 2'b00; oe_n = 1'b0;
        we_n = 1'b0; ce_n = 1'b1;
        tick();
        ce_n = 1'b0;
        tick();
        chk(lane_oe == '0, "R5 window opened by ce", 32'(lane_oe), 0);
        ce_n = 1'b1;
        tick();
        chk(lane_oe == '0, "R5 closing on ce", 32'(lane_oe), 0);
        idle_pins();
        tick();
        tick();
        do_read(10'd12, 2'b00, 2'b11, 16'h6A6A, "R7 close on ce rise");
    endtask

    task automatic t_last_sample();
        do_write(10'd20, 16'h0000, 2'b00);
        addr = 10'd20; wdata = 16'hAAAA; be_n = 2'b00; oe_n = 1'b1;
        ce_n = 1'b0; we_n = 1'b0;
        tick();
        wdata = 16'h5555; be_n = 2'b10;
        tick();
        we_n = 1'b1;
        tick();
        idle_pins();
        tick();
        tick();
        do_read(10'd20, 2'b00, 2'b11, 16'h0055, "R8 last in-window sample");
    endtask

    task automatic t_latency();
        do_write(10'd30, 16'h0101, 2'b00);
        addr = 10'd30; wdata = 16'hBEEF; be_n = 2'b00; oe_n = 1'b0;
        ce_n = 1'b0; we_n = 1'b0;
        tick();
        we_n = 1'b1;
        tick();
        chk(lane_oe == 2'b11, "R9 read on closing sample", 32'(lane_oe), 32'h3);
        chk(rdata == 16'h0101, "R9 old data at close edge", 32'(rdata), 32'h0101);
        tick();
        chk(rdata == 16'hBEEF, "R9 new data one edge later", 32'(rdata), 32'hBEEF);
        idle_pins();
        tick();
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1;
        rst_n = 1'b1;
        tick();
        t_reset();
        t_word_rw();
        t_byte_write();
        t_byte_read();
        t_standby();
        t_out_off();
        t_ce_close();
        t_last_sample();
        t_latency();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule